// File: doc/BRIEF.md
# Single-Wire Bus Master (HDQ / 1-Wire)

This block is a memory-mapped master for a single open-drain data wire. Software prepares a byte in the transmit register and starts an operation by writing the control register with its start bit set. The same start bit does one of three things. It sends a break pulse and checks for a presence answer when the initialization bit is set. Otherwise it shifts out a byte or a single bit when the direction bit is 0, or receives a byte or a single bit when the direction bit is 1. The start bit and the initialization bit read back as 1 while the work is in progress and drop by themselves when it ends.

Two timing sets are selected by a mode bit: 0 for HDQ and 1 for 1-Wire. Each set is a parameter record whose fields are lengths in system clock cycles. Completion raises one of three flags in an interrupt status register. A read of that register clears all three flags. The interrupt output is high while any flag is set and interrupts are enabled. A soft-reset request returns every register and the line engine to their reset state. A status bit shows when that reset has finished.

Register map (byte offsets; the addresses and bit positions are the software contract):

| Offset | Contents |
|--------|----------|
| 0x00 | version: major in bits 7:4, minor in bits 3:0 |
| 0x04 | transmit data |
| 0x08 | receive data |
| 0x0C | control: 7 single-bit, 6 irq enable, 5 clock enable, 4 start, 3 presence (read-only), 2 init, 1 direction, 0 mode |
| 0x10 | flags: 2 sent, 1 received, 0 break finished |
| 0x14 | config: 1 soft reset (reads 1 while active), 0 auto-idle |
| 0x18 | status: 0 reset done |

Top module: `swire_master`

## Requirements
- R1: After reset, version reads 0x21, control reads 0x00, flags read 0x00, config reads 0x00, status reads 0x01, and both the line drive and irq are low.
- R2: A control write with init, start and clock enable set (value 0x74 plus the mode bit) drives the line low for 40 cycles in HDQ mode or 60 cycles in 1-Wire mode. While this runs, control bits 4 and 2 read 1. When it ends, both bits read 0 and flag bit 0 is set.
- R3: The presence bit (control bit 3) is cleared when a break starts. It reads 1 after the break only if the line was low in the sampling window after the line was released.
- R4: With direction 0, start sends the transmit byte least significant bit first. Each bit is a low pulse of 6 cycles for a 1 and 24 cycles for a 0 in HDQ mode, or 4 and 18 cycles in 1-Wire mode. The end of the byte sets flag bit 2.
- R5: With direction 1, start issues 8 initiation pulses, each 3 cycles long in HDQ mode or 2 cycles in 1-Wire mode. It samples the line in each slot and fills the receive register least significant bit first (a low line is a 0). The end sets flag bit 1.
- R6: With control bit 7 set, a write sends only transmit bit 0. A read delivers the single received bit at receive bit 0, with bits 7:1 at zero.
- R7: A read of the flags register returns the flags, and the next read returns 0x00.
- R8: irq is high exactly while a flag is set and control bit 6 is 1. With bit 6 at 0, flags still set but irq stays low.
- R9: While an operation runs, a control write can change only the irq enable and clock enable bits. A second start, a change of direction, mode or init, and the single-bit setting are all ignored. The running operation completes unchanged.
- R10: A start written with clock enable at 0 begins nothing: the line stays released, no flag is set, and bit 4 reads 0.
- R11: Writing config bit 1 aborts any operation and releases the line. It holds status bit 0 at 0 for 16 cycles, then leaves all registers at their reset values. Config bit 0 is stored and reads back.
- R12: The mode bit latched at start selects the timing set used for the whole operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (reading the flags clears them) |
| reg_addr | input | 5 | register byte offset |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data, combinational from reg_addr |
| irq | output | 1 | interrupt request |
| line_drive_low | output | 1 | 1 pulls the open-drain wire low |
| line_in | input | 1 | sensed level of the wire |

## Verification
A wrong slot counter or bit index shows at the pins within the same operation. The width of a low pulse or the number of pulses per byte changes on the wire, and the bench measures every pulse in cycles. A corrupt shift register or sample point shows in the receive byte as soon as the completion flag rises, which is one slot after the last bit. A stuck busy state shows up as a start bit that never drops or a flag that never appears, and the bench polls for both with a cycle limit. Flag-clear and interrupt-gating faults appear on the very next register read.

// File: rtl/swire_pkg.sv
package swire_pkg;

  localparam int unsigned DW = 8;
  localparam int unsigned AW = 5;

  localparam logic [AW-1:0] A_REV  = 5'h00;
  localparam logic [AW-1:0] A_TX   = 5'h04;
  localparam logic [AW-1:0] A_RX   = 5'h08;
  localparam logic [AW-1:0] A_CTRL = 5'h0C;
  localparam logic [AW-1:0] A_FLAG = 5'h10;
  localparam logic [AW-1:0] A_CFG  = 5'h14;
  localparam logic [AW-1:0] A_STAT = 5'h18;

  localparam int C_SINGLE = 7;
  localparam int C_IE     = 6;
  localparam int C_CLKEN  = 5;
  localparam int C_GO     = 4;
  localparam int C_PRES   = 3;
  localparam int C_INIT   = 2;
  localparam int C_DIR    = 1;
  localparam int C_MODE   = 0;

  localparam int F_SENT  = 2;
  localparam int F_RECV  = 1;
  localparam int F_BREAK = 0;

  typedef enum logic [1:0] {OP_BREAK, OP_WRITE, OP_READ} op_e;

  typedef struct packed {
    logic [15:0] brk_low;
    logic [15:0] brk_rec;
    logic [15:0] pres_at;
    logic [15:0] slot;
    logic [15:0] low_one;
    logic [15:0] low_zero;
    logic [15:0] rd_low;
    logic [15:0] rd_smp;
  } line_timing_t;

  localparam line_timing_t HDQ_DEFAULT = '{
    brk_low: 16'd40, brk_rec: 16'd30, pres_at: 16'd12, slot: 16'd40,
    low_one: 16'd6, low_zero: 16'd24, rd_low: 16'd3, rd_smp: 16'd15};

  localparam line_timing_t OW_DEFAULT = '{
    brk_low: 16'd60, brk_rec: 16'd50, pres_at: 16'd15, slot: 16'd30,
    low_one: 16'd4, low_zero: 16'd18, rd_low: 16'd2, rd_smp: 16'd10};

endpackage

// File: rtl/swire_rstseq.sv
module swire_rstseq #(
  parameter int unsigned SRST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic active
);
  localparam int unsigned CW = $clog2(SRST_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_n  = cnt_q;
    if (req && (cnt_q == '0)) begin
      cnt_en = 1'b1;
      cnt_n  = CW'(SRST_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_n  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign active = (cnt_q != '0);

endmodule

// File: rtl/swire_engine.sv
module swire_engine import swire_pkg::*; #(
  parameter line_timing_t HDQ_TIMING = HDQ_DEFAULT,
  parameter line_timing_t OW_TIMING  = OW_DEFAULT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          start,
  input  op_e           op,
  input  logic          single,
  input  logic          mode,
  input  logic [DW-1:0] tx_byte,
  input  logic          line_in,
  output logic          line_drive,
  output logic          busy,
  output logic          tx_done,
  output logic          rx_done,
  output logic          brk_done,
  output logic [DW-1:0] rx_byte,
  output logic          pres_val
);
  typedef enum logic [1:0] {ST_IDLE, ST_BRK_LO, ST_BRK_HI, ST_SLOT} eng_st_e;

  localparam int unsigned BW = $clog2(DW);

  eng_st_e       st_q, st_n;
  op_e           op_q, op_n;
  logic          mode_q, mode_n;
  logic          single_q, single_n;
  logic [15:0]   cnt_q, cnt_n;
  logic [BW-1:0] bit_q, bit_n;
  logic [DW-1:0] sh_q, sh_n;
  logic          pres_q, pres_n;
  logic [1:0]    sync_q;
  logic          line_s;
  line_timing_t  tim;
  logic [15:0]   low_len;
  logic [BW-1:0] last_bit;

  // two-flop synchronizer on the sensed wire level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], line_in};
  end
  assign line_s = sync_q[1];

  assign tim      = mode_q ? OW_TIMING : HDQ_TIMING;
  assign last_bit = single_q ? '0 : BW'(DW - 1);
  assign low_len  = (op_q == OP_READ) ? tim.rd_low :
                    (sh_q[0] ? tim.low_one : tim.low_zero);

  always_comb begin
    st_n     = st_q;
    op_n     = op_q;
    mode_n   = mode_q;
    single_n = single_q;
    cnt_n    = cnt_q;
    bit_n    = bit_q;
    sh_n     = sh_q;
    pres_n   = pres_q;
    tx_done  = 1'b0;
    rx_done  = 1'b0;
    brk_done = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          op_n     = op;
          mode_n   = mode;
          single_n = single;
          sh_n     = tx_byte;
          bit_n    = '0;
          cnt_n    = '0;
          pres_n   = 1'b0;
          st_n     = (op == OP_BREAK) ? ST_BRK_LO : ST_SLOT;
        end
      end
      ST_BRK_LO: begin
        if (cnt_q == tim.brk_low - 16'd1) begin
          st_n  = ST_BRK_HI;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + 16'd1;
        end
      end
      ST_BRK_HI: begin
        if ((cnt_q == tim.pres_at) && !line_s) pres_n = 1'b1;
        if (cnt_q == tim.brk_rec - 16'd1) begin
          st_n     = ST_IDLE;
          brk_done = 1'b1;
        end else begin
          cnt_n = cnt_q + 16'd1;
        end
      end
      ST_SLOT: begin
        if ((op_q == OP_READ) && (cnt_q == tim.rd_smp))
          sh_n = {line_s, sh_q[DW-1:1]};
        if (cnt_q == tim.slot - 16'd1) begin
          cnt_n = '0;
          if (bit_q == last_bit) begin
            st_n = ST_IDLE;
            if (op_q == OP_READ) rx_done = 1'b1;
            else                 tx_done = 1'b1;
          end else begin
            bit_n = bit_q + 1'b1;
            if (op_q == OP_WRITE) sh_n = {1'b0, sh_q[DW-1:1]};
          end
        end else begin
          cnt_n = cnt_q + 16'd1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_WRITE;
      mode_q   <= 1'b0;
      single_q <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      pres_q   <= 1'b0;
    end else if (clr) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_WRITE;
      mode_q   <= 1'b0;
      single_q <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      pres_q   <= 1'b0;
    end else begin
      st_q     <= st_n;
      op_q     <= op_n;
      mode_q   <= mode_n;
      single_q <= single_n;
      cnt_q    <= cnt_n;
      bit_q    <= bit_n;
      sh_q     <= sh_n;
      pres_q   <= pres_n;
    end
  end

  assign line_drive = (st_q == ST_BRK_LO) || ((st_q == ST_SLOT) && (cnt_q < low_len));
  assign busy       = (st_q != ST_IDLE);
  assign rx_byte    = single_q ? {{(DW-1){1'b0}}, sh_q[DW-1]} : sh_q;
  assign pres_val   = pres_q;

  // R9: the register file never launches an operation into a busy engine
  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == ST_IDLE));

  // R4: the slot counter stays inside the slot length
  p_slot_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLOT) |-> (cnt_q < tim.slot));

endmodule

// File: rtl/swire_regs.sv
module swire_regs import swire_pkg::*; #(
  parameter logic [3:0] REV_MAJOR = 4'd2,
  parameter logic [3:0] REV_MINOR = 4'd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  input  logic          busy,
  input  logic          tx_done,
  input  logic          rx_done,
  input  logic          brk_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          pres_val,
  output logic          start,
  output op_e           op,
  output logic          single,
  output logic          mode,
  output logic [DW-1:0] tx_byte,
  output logic          srst_req
);
  logic          single_q, ie_q, clken_q, init_q, dir_q, mode_q, pres_q, idle_cfg_q;
  logic          single_n, ie_n, clken_n, init_n, dir_n, mode_n, pres_n, idle_cfg_n;
  logic [DW-1:0] tx_q, tx_n, rx_q, rx_n;
  logic [2:0]    flag_q, flag_n;
  logic          wr_tx, wr_ctrl, wr_cfg, rd_flag, ctrl_load;

  assign wr_tx     = reg_wr && (reg_addr == A_TX)   && !clr;
  assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL) && !clr;
  assign wr_cfg    = reg_wr && (reg_addr == A_CFG)  && !clr;
  assign rd_flag   = reg_rd && (reg_addr == A_FLAG) && !clr;
  assign ctrl_load = wr_ctrl && !busy;

  assign start    = ctrl_load && reg_wdata[C_GO] && reg_wdata[C_CLKEN];
  assign op       = reg_wdata[C_INIT] ? OP_BREAK : (reg_wdata[C_DIR] ? OP_READ : OP_WRITE);
  assign single   = reg_wdata[C_SINGLE];
  assign mode     = reg_wdata[C_MODE];
  assign tx_byte  = tx_q;
  assign srst_req = wr_cfg && reg_wdata[1];

  always_comb begin
    single_n   = single_q;
    ie_n       = ie_q;
    clken_n    = clken_q;
    init_n     = init_q;
    dir_n      = dir_q;
    mode_n     = mode_q;
    pres_n     = pres_q;
    idle_cfg_n = idle_cfg_q;
    tx_n       = wr_tx ? reg_wdata : tx_q;
    rx_n       = rx_done ? rx_byte : rx_q;
    if (wr_ctrl) begin
      ie_n    = reg_wdata[C_IE];
      clken_n = reg_wdata[C_CLKEN];
    end
    if (ctrl_load) begin
      single_n = reg_wdata[C_SINGLE];
      init_n   = reg_wdata[C_INIT];
      dir_n    = reg_wdata[C_DIR];
      mode_n   = reg_wdata[C_MODE];
    end
    if (start && (op == OP_BREAK)) pres_n = 1'b0;
    if (brk_done) begin
      pres_n = pres_val;
      init_n = 1'b0;
    end
    if (wr_cfg) idle_cfg_n = reg_wdata[0];
    flag_n = rd_flag ? 3'b000 : flag_q;
    flag_n[F_SENT]  = flag_n[F_SENT]  | tx_done;
    flag_n[F_RECV]  = flag_n[F_RECV]  | rx_done;
    flag_n[F_BREAK] = flag_n[F_BREAK] | brk_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_q <= 1'b0; ie_q <= 1'b0; clken_q <= 1'b0; init_q <= 1'b0;
      dir_q <= 1'b0; mode_q <= 1'b0; pres_q <= 1'b0; idle_cfg_q <= 1'b0;
      tx_q <= '0; rx_q <= '0; flag_q <= '0;
    end else if (clr) begin
      single_q <= 1'b0; ie_q <= 1'b0; clken_q <= 1'b0; init_q <= 1'b0;
      dir_q <= 1'b0; mode_q <= 1'b0; pres_q <= 1'b0; idle_cfg_q <= 1'b0;
      tx_q <= '0; rx_q <= '0; flag_q <= '0;
    end else begin
      single_q <= single_n; ie_q <= ie_n; clken_q <= clken_n; init_q <= init_n;
      dir_q <= dir_n; mode_q <= mode_n; pres_q <= pres_n; idle_cfg_q <= idle_cfg_n;
      tx_q <= tx_n; rx_q <= rx_n; flag_q <= flag_n;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_REV:   reg_rdata = {REV_MAJOR, REV_MINOR};
      A_TX:    reg_rdata = tx_q;
      A_RX:    reg_rdata = rx_q;
      A_CTRL:  reg_rdata = {single_q, ie_q, clken_q, busy, pres_q, init_q, dir_q, mode_q};
      A_FLAG:  reg_rdata = {5'b0, flag_q};
      A_CFG:   reg_rdata = {6'b0, clr, idle_cfg_q};
      A_STAT:  reg_rdata = {7'b0, !clr};
      default: reg_rdata = '0;
    endcase
  end

  assign irq = ie_q && (flag_q != 3'b000);

  // R7: a flag read with no new event leaves every flag clear
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flag && !(tx_done || rx_done || brk_done)) |=> (flag_q == 3'b000));

  // R3: a starting break drops the old presence result
  p_presence_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op == OP_BREAK)) |=> !pres_q);

  // R6: single-bit receive leaves the upper receive bits at zero
  p_rx_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && single_q && !clr) |=> (rx_q[DW-1:1] == '0));

  // R8: an engine completion with interrupts on raises irq next cycle
  p_irq_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q && !wr_ctrl && !clr && (tx_done || rx_done || brk_done)) |=> irq);

endmodule

// File: rtl/swire_master.sv
module swire_master import swire_pkg::*; #(
  parameter line_timing_t HDQ_TIMING  = HDQ_DEFAULT,
  parameter line_timing_t OW_TIMING   = OW_DEFAULT,
  parameter int unsigned  SRST_CYCLES = 16,
  parameter logic [3:0]   REV_MAJOR   = 4'd2,
  parameter logic [3:0]   REV_MINOR   = 4'd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          line_drive_low,
  input  logic          line_in
);
  logic          rst_meta, rst_sync_n;
  logic          srst_req, srst_active;
  logic          start, single, mode, busy;
  logic          tx_done, rx_done, brk_done, pres_val;
  op_e           op;
  logic [DW-1:0] tx_byte, rx_byte;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  swire_rstseq #(.SRST_CYCLES(SRST_CYCLES)) u_rstseq (
    .clk(clk), .rst_n(rst_sync_n), .req(srst_req), .active(srst_active));

  swire_regs #(.REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .clr(srst_active),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .busy(busy), .tx_done(tx_done), .rx_done(rx_done), .brk_done(brk_done),
    .rx_byte(rx_byte), .pres_val(pres_val),
    .start(start), .op(op), .single(single), .mode(mode),
    .tx_byte(tx_byte), .srst_req(srst_req));

  swire_engine #(.HDQ_TIMING(HDQ_TIMING), .OW_TIMING(OW_TIMING)) u_engine (
    .clk(clk), .rst_n(rst_sync_n), .clr(srst_active),
    .start(start), .op(op), .single(single), .mode(mode), .tx_byte(tx_byte),
    .line_in(line_in), .line_drive(line_drive_low), .busy(busy),
    .tx_done(tx_done), .rx_done(rx_done), .brk_done(brk_done),
    .rx_byte(rx_byte), .pres_val(pres_val));

  // R11: soft reset releases the wire from the following cycle on
  p_srst_release_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    srst_active |=> !line_drive_low);

endmodule

// File: tb/swire_master_tb_top.sv
module swire_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq, line_drive_low, line_in;
  logic       pres_pull, data_pull, rd_en;
  logic [7:0] rd_pat;
  int         rd_idx, nw, n_chk, n_fail;
  int         wid [0:15];

  localparam logic [4:0] A_REV = 5'h00, A_TX = 5'h04, A_RX = 5'h08, A_CTRL = 5'h0C,
                         A_FLAG = 5'h10, A_CFG = 5'h14, A_STAT = 5'h18;
  localparam int NV = 7;
  // {mode, single, dir, byte}
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5}, {1'b1, 1'b0, 1'b0, 8'h3C},
    {1'b0, 1'b0, 1'b1, 8'h96}, {1'b1, 1'b0, 1'b1, 8'h5A},
    {1'b0, 1'b1, 1'b0, 8'h01}, {1'b1, 1'b1, 1'b1, 8'hFE},
    {1'b0, 1'b1, 1'b1, 8'h01}};

  always #4 clk = ~clk;

  assign line_in = ~(line_drive_low | pres_pull | data_pull);

  swire_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .line_drive_low(line_drive_low), .line_in(line_in));

  // wire monitor and responding slave
  initial begin
    forever begin
      int w;
      @(posedge line_drive_low);
      if (rd_en && rd_idx < 8) begin
        data_pull = ~rd_pat[rd_idx];
        rd_idx++;
      end
      w = 0;
      @(negedge clk);
      while (line_drive_low) begin
        w++;
        @(negedge clk);
      end
      if (nw < 16) wid[nw] = w;
      nw++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] v;
    bit done = 0;
    for (int i = 0; i < 3000 && !done; i++) begin
      rd(A_CTRL, v);
      if (!v[4]) done = 1;
    end
    chk({req, " start bit self-clears"}, int'(done), 1);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1..R12 actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    n_chk = 0; n_fail = 0; nw = 0; rd_idx = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    pres_pull = 1'b0; data_pull = 1'b0; rd_en = 1'b0; rd_pat = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    rd(A_REV, v);  chk("R1 version", v, 8'h21);
    rd(A_CTRL, v); chk("R1 control", v, 8'h00);
    rd(A_FLAG, v); chk("R1 flags", v, 8'h00);
    rd(A_CFG, v);  chk("R1 config", v, 8'h00);
    rd(A_STAT, v); chk("R1 status", v, 8'h01);
    chk("R1 line released", line_drive_low, 0);
    chk("R1 irq low", irq, 0);

    // table walk: R4 R5 R6 R12
    for (int i = 0; i < NV; i++) begin
      logic m, s, d;
      logic [7:0] b;
      int nb, t1, t0, tr;
      {m, s, d, b} = VEC[i];
      nb = s ? 1 : 8;
      t1 = m ? 4 : 6; t0 = m ? 18 : 24; tr = m ? 2 : 3;
      wr(A_TX, b);
      nw = 0; rd_idx = 0; rd_pat = b; rd_en = d;
      wr(A_CTRL, {s, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, d, m});
      wait_idle("R4/R5");
      chk("R8 irq after completion", irq, 1);
      rd(A_FLAG, v); chk(d ? "R5 receive flag" : "R4 send flag", v, d ? 8'h02 : 8'h04);
      rd(A_FLAG, v); chk("R7 flags clear after read", v, 8'h00);
      chk("R8 irq low after clear", irq, 0);
      chk(s ? "R6 single-bit pulse count" : "R4/R5 pulse count", nw, nb);
      for (int k = 0; k < nb; k++)
        chk(d ? "R5 R12 initiation width" : "R4 R12 bit width", wid[k], d ? tr : (b[k] ? t1 : t0));
      if (d) begin
        rd(A_RX, v);
        chk(s ? "R6 single received bit" : "R5 received byte", v, s ? {7'b0, b[0]} : b);
      end
      rd_en = 1'b0; data_pull = 1'b0;
    end

    // R2 R3 R12 breaks in both modes, with and without a responder
    for (int m = 0; m < 2; m++) begin
      for (int p = 1; p >= 0; p--) begin
        pres_pull = p[0]; nw = 0;
        wr(A_CTRL, 8'h74 | 8'(m));
        rd(A_CTRL, v); chk("R2 R3 busy control during break", v, 8'h74 | 8'(m));
        wait_idle("R2");
        rd(A_CTRL, v); chk("R2 R3 control after break", v, 8'h60 | 8'(m) | (p[0] ? 8'h08 : 8'h00));
        rd(A_FLAG, v); chk("R2 break flag", v, 8'h01);
        chk("R2 R12 break width", wid[0], m ? 60 : 40);
        chk("R2 single break pulse", nw, 1);
        pres_pull = 1'b0;
      end
    end

    // R8 interrupt gated off
    wr(A_TX, 8'h00); nw = 0;
    wr(A_CTRL, 8'h30);
    wait_idle("R8");
    chk("R8 irq stays low with enable off", irq, 0);
    rd(A_FLAG, v); chk("R8 flag set without irq", v, 8'h04);

    // R9 writes during a running operation
    wr(A_TX, 8'hFF); nw = 0;
    wr(A_CTRL, 8'h70);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 8'h77);
    wait_idle("R9");
    chk("R9 pulse count unchanged", nw, 8);
    for (int k = 0; k < 8; k++) chk("R9 bit width unchanged", wid[k], 6);
    rd(A_FLAG, v); chk("R9 only send flag", v, 8'h04);
    rd(A_CTRL, v); chk("R9 control kept", v, 8'h60);

    // R10 start without clock enable
    nw = 0;
    wr(A_CTRL, 8'h50);
    repeat (100) @(negedge clk);
    chk("R10 no line activity", nw, 0);
    rd(A_CTRL, v); chk("R10 start not taken", v, 8'h40);
    rd(A_FLAG, v); chk("R10 no flag", v, 8'h00);

    // R11 soft reset in the middle of a break
    wr(A_CTRL, 8'h74);
    repeat (10) @(negedge clk);
    wr(A_CFG, 8'h02);
    rd(A_STAT, v); chk("R11 reset in progress", v, 8'h00);
    chk("R11 line released", line_drive_low, 0);
    repeat (20) @(negedge clk);
    rd(A_STAT, v); chk("R11 reset done", v, 8'h01);
    rd(A_CTRL, v); chk("R11 control cleared", v, 8'h00);
    rd(A_FLAG, v); chk("R11 no flag after abort", v, 8'h00);
    rd(A_CFG, v);  chk("R11 config cleared", v, 8'h00);
    chk("R11 irq low", irq, 0);
    wr(A_CFG, 8'h01);
    rd(A_CFG, v);  chk("R11 auto-idle stored", v, 8'h01);

    summary();
    $finish;
  end
endmodule